// File: doc/BRIEF.md
# Segment Address Translation Unit

This unit converts a segment value and an offset into a linear address. The current mode is held in a protection-enable bit. When the bit is clear, the unit runs in real mode: it shifts the segment value left by four bits and adds the offset, and it makes no checks. When the bit is set, the unit runs in protected mode. The segment value becomes an index into a small descriptor table kept in registers. The linear address is the base of the selected descriptor plus the offset. The request is refused if the index lies outside the table, if the descriptor is absent, if the caller's privilege is too weak, or if the offset reaches the descriptor limit.

Requests enter through a valid/ready port and results leave through a second valid/ready port. There is one output register. A request accepted on a clock edge shows up as a response on the next cycle. `req_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and no new request is taken. Table writes and mode changes arrive on plain control pins. They take effect only when the caller's privilege level is 0, which is kernel; level 3 is user.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, no response is pending, `req_ready` is high, the unit is in real mode, and every descriptor reads as not present.
- R2: In real mode the result is (segment << 4) + offset, truncated to 32 bits, and the fault cause is 0. This holds for every segment value, including values beyond the table size.
- R3: In protected mode, with no fault, the result is descriptor base + offset, truncated to 32 bits.
- R4: In protected mode, an offset that is greater than or equal to the 20-bit descriptor limit faults with cause 4. A limit of 0 therefore always faults.
- R5: In protected mode, a segment value greater than or equal to NUM_DESC faults with cause 1.
- R6: In protected mode, a descriptor whose present bit is clear faults with cause 2.
- R7: In protected mode, a current privilege level numerically greater than the descriptor privilege level faults with cause 3.
- R8: When several faults apply, the lowest-numbered cause wins (1, then 2, then 3, then 4). `rsp_fault` is high exactly when the cause is not 0.
- R9: Writes to the descriptor table and to the protection-enable bit are ignored unless `cpl` is 0. A table write whose index is at or beyond NUM_DESC is also ignored.
- R10: A request accepted on one edge gives `rsp_valid` high in the following cycle. While `rsp_valid` is high and `rsp_ready` is low, the response stays stable. `req_ready` equals `!rsp_valid || rsp_ready`.
- R11: A faulting response carries `rsp_addr` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl | input | 2 | Current privilege level of the caller |
| cfg_pe_we | input | 1 | Write strobe for the protection-enable bit |
| cfg_pe_wdata | input | 1 | New protection-enable value |
| dt_we | input | 1 | Descriptor table write strobe |
| dt_widx | input | 16 | Descriptor index to write |
| dt_wbase | input | 32 | Base written into the descriptor |
| dt_wlimit | input | 20 | Limit written into the descriptor |
| dt_wdpl | input | 2 | Privilege level written into the descriptor |
| dt_wpresent | input | 1 | Present bit written into the descriptor |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_seg | input | 16 | Segment value or selector index |
| req_off | input | 32 | Logical offset |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_addr | output | 32 | Linear address, 0 on fault |
| rsp_fault | output | 1 | Translation refused |
| rsp_cause | output | 3 | 0 none, 1 index range, 2 absent, 3 privilege, 4 limit |

## Verification
The assertions take for granted that the downstream consumer may hold `rsp_ready` low for any number of cycles. They also assume that `cpl` is sampled on the same edge as any write strobe it qualifies. The stimulus never changes the table or the mode on the edge that accepts a request that is being scored. This keeps each expected result tied to one known table state. The bench drives `rsp_ready` from a pseudo-random sequence only in a burst phase. Every other input changes just after a rising edge, so each handshake sees settled values.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int LIN_W = 32;
  localparam int SEL_W = 16;
  localparam int LIM_W = 20;
  localparam int PL_W  = 2;
  localparam int CAUSE_W = 3;

  typedef struct packed {
    logic [LIN_W-1:0] base;
    logic [LIM_W-1:0] limit;
    logic [PL_W-1:0]  dpl;
    logic             present;
  } seg_desc_t;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_RANGE  = 3'd1,
    CAUSE_ABSENT = 3'd2,
    CAUSE_PRIV   = 3'd3,
    CAUSE_LIMIT  = 3'd4
  } fault_cause_e;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int NUM_DESC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  seg_desc_t        wr_desc,
  input  logic [SEL_W-1:0] rd_idx,
  output seg_desc_t        rd_desc,
  output logic             rd_hit
);
  seg_desc_t entries [NUM_DESC];

  // One register slot per descriptor; out-of-range writes match no slot.
  for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entries[g] <= '0;
      end else if (wr_en && (wr_idx == SEL_W'(g))) begin
        entries[g] <= wr_desc;
      end
    end
  end

  always_comb begin
    rd_desc = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (rd_idx == SEL_W'(i)) rd_desc = entries[i];
    end
  end

  assign rd_hit = ({16'd0, rd_idx} < 32'(NUM_DESC));
endmodule

// File: rtl/seg_fault_check.sv
module seg_fault_check
  import seg_xlate_pkg::*;
(
  input  logic             prot_en,
  input  logic [PL_W-1:0]  cur_pl,
  input  logic [LIN_W-1:0] offset,
  input  seg_desc_t        desc,
  input  logic             idx_hit,
  output fault_cause_e     cause
);
  localparam int PAD_W = LIN_W - LIM_W;

  logic over_limit;
  assign over_limit = (offset >= {{PAD_W{1'b0}}, desc.limit});

  // Priority: index range, presence, privilege, then limit.
  always_comb begin
    cause = CAUSE_NONE;
    if (prot_en) begin
      if (!idx_hit)                cause = CAUSE_RANGE;
      else if (!desc.present)      cause = CAUSE_ABSENT;
      else if (cur_pl > desc.dpl)  cause = CAUSE_PRIV;
      else if (over_limit)         cause = CAUSE_LIMIT;
    end
  end
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import seg_xlate_pkg::*;
#(
  parameter int REAL_SHIFT = 4
) (
  input  logic             prot_en,
  input  logic [SEL_W-1:0] seg,
  input  logic [LIN_W-1:0] offset,
  input  logic [LIN_W-1:0] base,
  input  fault_cause_e     cause,
  output logic [LIN_W-1:0] lin_addr
);
  localparam int HI_PAD = LIN_W - SEL_W - REAL_SHIFT;

  logic [LIN_W-1:0] real_base;
  assign real_base = {{HI_PAD{1'b0}}, seg, {REAL_SHIFT{1'b0}}};

  always_comb begin
    if (cause != CAUSE_NONE) lin_addr = '0;
    else if (prot_en)        lin_addr = base + offset;
    else                     lin_addr = real_base + offset;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_DESC   = 8,
  parameter int REAL_SHIFT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cpl,
  input  logic        cfg_pe_we,
  input  logic        cfg_pe_wdata,
  input  logic        dt_we,
  input  logic [15:0] dt_widx,
  input  logic [31:0] dt_wbase,
  input  logic [19:0] dt_wlimit,
  input  logic [1:0]  dt_wdpl,
  input  logic        dt_wpresent,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_seg,
  input  logic [31:0] req_off,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_addr,
  output logic        rsp_fault,
  output logic [2:0]  rsp_cause
);
  logic         kernel_pl;
  logic         pe_q;
  seg_desc_t    wr_desc;
  seg_desc_t    sel_desc;
  logic         sel_hit;
  fault_cause_e cause_d;
  logic [LIN_W-1:0] addr_d;
  logic         accept;
  logic         rsp_valid_q;
  logic [LIN_W-1:0] rsp_addr_q;
  fault_cause_e rsp_cause_q;

  assign kernel_pl = (cpl == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                        pe_q <= 1'b0;
    else if (cfg_pe_we && kernel_pl)   pe_q <= cfg_pe_wdata;
  end

  assign wr_desc = '{base: dt_wbase, limit: dt_wlimit, dpl: dt_wdpl, present: dt_wpresent};

  seg_desc_table #(.NUM_DESC(NUM_DESC)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dt_we && kernel_pl),
    .wr_idx  (dt_widx),
    .wr_desc (wr_desc),
    .rd_idx  (req_seg),
    .rd_desc (sel_desc),
    .rd_hit  (sel_hit)
  );

  seg_fault_check u_check (
    .prot_en (pe_q),
    .cur_pl  (cpl),
    .offset  (req_off),
    .desc    (sel_desc),
    .idx_hit (sel_hit),
    .cause   (cause_d)
  );

  seg_addr_calc #(.REAL_SHIFT(REAL_SHIFT)) u_addr (
    .prot_en  (pe_q),
    .seg      (req_seg),
    .offset   (req_off),
    .base     (sel_desc.base),
    .cause    (cause_d),
    .lin_addr (addr_d)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_addr_q  <= '0;
      rsp_cause_q <= CAUSE_NONE;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_addr_q  <= addr_d;
      rsp_cause_q <= cause_d;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_addr  = rsp_addr_q;
  assign rsp_cause = rsp_cause_q;
  assign rsp_fault = (rsp_cause_q != CAUSE_NONE);
endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cpl,
  input logic        pe_q,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_addr,
  input logic        rsp_fault,
  input logic [2:0]  rsp_cause
);
  p_accept_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_cause)));

  p_fault_zero_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == 32'd0));

  p_real_no_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !pe_q) |=> !rsp_fault);

  p_pe_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl != 2'd0) |=> $stable(pe_q));

  p_cause_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cause <= 3'd4));
endmodule

bind seg_xlate_unit seg_xlate_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpl       (cpl),
  .pe_q      (pe_q),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause)
);

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/100ps
module seg_xlate_unit_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic        cfg_pe_we = 1'b0, cfg_pe_wdata = 1'b0;
  logic        dt_we = 1'b0;
  logic [15:0] dt_widx = '0;
  logic [31:0] dt_wbase = '0;
  logic [19:0] dt_wlimit = '0;
  logic [1:0]  dt_wdpl = '0;
  logic        dt_wpresent = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_seg = '0;
  logic [31:0] req_off = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;

  seg_xlate_unit #(.NUM_DESC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpl(cpl),
    .cfg_pe_we(cfg_pe_we), .cfg_pe_wdata(cfg_pe_wdata),
    .dt_we(dt_we), .dt_widx(dt_widx), .dt_wbase(dt_wbase),
    .dt_wlimit(dt_wlimit), .dt_wdpl(dt_wdpl), .dt_wpresent(dt_wpresent),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] addr;
    logic [2:0]  cause;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // Bench-side model state
  logic [31:0] m_base  [N];
  logic [19:0] m_limit [N];
  logic [1:0]  m_dpl   [N];
  logic        m_pres  [N];
  logic        m_pe = 1'b0;
  logic        bp_en = 1'b0;
  logic [15:0] bp_lfsr = 16'hACE1;
  logic [31:0] rnd = 32'h1234_5678;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [1:0] c, input logic [15:0] s,
                                   input logic [31:0] o, input string tag);
    exp_t e;
    e.tag = tag;
    e.cause = 3'd0;
    e.addr = 32'd0;
    if (!m_pe) begin
      e.addr = {12'd0, s, 4'd0} + o;
    end else if (int'(s) >= N) begin
      e.cause = 3'd1;
    end else if (!m_pres[s[2:0]]) begin
      e.cause = 3'd2;
    end else if (c > m_dpl[s[2:0]]) begin
      e.cause = 3'd3;
    end else if (o >= {12'd0, m_limit[s[2:0]]}) begin
      e.cause = 3'd4;
    end else begin
      e.addr = m_base[s[2:0]] + o;
    end
    return e;
  endfunction

  // Called just after a rising edge; leaves req_valid high for back-to-back use.
  task automatic send(input logic [1:0] c, input logic [15:0] s, input logic [31:0] o,
                      input string tag);
    cpl = c; req_seg = s; req_off = o; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    exp_q.push_back(predict(c, s, o, tag));
    @(posedge clk); #1;
  endtask

  task automatic idle();
    req_valid = 1'b0;
  endtask

  task automatic wr_pe(input logic [1:0] c, input logic v);
    idle();
    cpl = c; cfg_pe_we = 1'b1; cfg_pe_wdata = v;
    @(posedge clk); #1;
    cfg_pe_we = 1'b0;
    if (c == 2'd0) m_pe = v;
  endtask

  task automatic wr_desc(input logic [1:0] c, input logic [15:0] idx, input logic [31:0] b,
                         input logic [19:0] l, input logic [1:0] d, input logic p);
    idle();
    cpl = c; dt_we = 1'b1; dt_widx = idx; dt_wbase = b; dt_wlimit = l; dt_wdpl = d; dt_wpresent = p;
    @(posedge clk); #1;
    dt_we = 1'b0;
    if (c == 2'd0 && int'(idx) < N) begin
      m_base[idx[2:0]] = b; m_limit[idx[2:0]] = l; m_dpl[idx[2:0]] = d; m_pres[idx[2:0]] = p;
    end
  endtask

  task automatic drain();
    idle();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
    #1;
    if (exp_q.size() != 0) check("R10 drain queue empty", 32'(exp_q.size()), 32'd0);
  endtask

  // Back-pressure driver
  initial forever begin
    @(posedge clk); #1;
    if (bp_en) begin
      bp_lfsr = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
      rsp_ready = bp_lfsr[0];
    end else begin
      rsp_ready = 1'b1;
    end
  end

  // Monitor / scoreboard
  logic        hold_pend = 1'b0;
  logic [31:0] hold_addr;
  logic [2:0]  hold_cause;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (hold_pend) begin
        check("R10 held valid", {31'd0, rsp_valid}, 32'd1);
        check("R10 held addr", rsp_addr, hold_addr);
        check("R10 held cause", {29'd0, rsp_cause}, {29'd0, hold_cause});
      end
      check("R10 ready rule", {31'd0, req_ready}, {31'd0, (!rsp_valid || rsp_ready)});
      hold_pend = rsp_valid && !rsp_ready;
      hold_addr = rsp_addr;
      hold_cause = rsp_cause;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " addr"}, rsp_addr, e.addr);
          check({e.tag, " cause"}, {29'd0, rsp_cause}, {29'd0, e.cause});
          check({e.tag, " R8 fault flag"}, {31'd0, rsp_fault}, {31'd0, (e.cause != 3'd0)});
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_dpl[i] = '0; m_pres[i] = 1'b0;
    end
    repeat (4) @(posedge clk);
    #1;
    check("R1 no response in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
    @(posedge clk); #1;

    // R1, R2: real mode after reset
    send(2'd3, 16'h1234, 32'h0000_0005, "R1 R2 real basic");
    send(2'd0, 16'hFFFF, 32'hFFFF_FFF0, "R2 real wrap");
    send(2'd3, 16'h0020, 32'h0000_0100, "R2 real seg beyond table");
    drain();

    // R9: user cannot enable protection
    wr_pe(2'd3, 1'b1);
    send(2'd0, 16'h0040, 32'h0000_0001, "R9 pe write from user ignored");
    drain();

    wr_pe(2'd0, 1'b1);
    send(2'd0, 16'h0001, 32'h0, "R1 R6 empty descriptor absent");
    drain();

    wr_desc(2'd0, 16'd1, 32'h0040_0000, 20'h01000, 2'd3, 1'b1);
    wr_desc(2'd0, 16'd2, 32'h8000_0000, 20'hFFFFF, 2'd0, 1'b1);
    wr_desc(2'd0, 16'd3, 32'h1111_0000, 20'h00000, 2'd0, 1'b0);
    wr_desc(2'd0, 16'd5, 32'h0000_1000, 20'h00010, 2'd2, 1'b1);
    wr_desc(2'd0, 16'd6, 32'hFFFF_FF00, 20'h00000, 2'd3, 1'b1);
    wr_desc(2'd0, 16'd7, 32'hFFFF_FFF0, 20'h00100, 2'd3, 1'b1);
    // R9: user write and out-of-range write are dropped
    wr_desc(2'd3, 16'd4, 32'h0123_0000, 20'h00100, 2'd3, 1'b1);
    wr_desc(2'd0, 16'd9, 32'hDEAD_0000, 20'hFFFFF, 2'd3, 1'b1);

    send(2'd3, 16'd1, 32'h0, "R3 base plus zero");
    send(2'd3, 16'd1, 32'h0000_0FFF, "R3 R4 last offset in limit");
    send(2'd3, 16'd1, 32'h0000_1000, "R4 R11 offset equals limit");
    send(2'd3, 16'd1, 32'hFFFF_FFFF, "R4 R11 huge offset");
    send(2'd3, 16'd2, 32'h10, "R7 user to kernel descriptor");
    send(2'd0, 16'd2, 32'h10, "R3 kernel to kernel descriptor");
    send(2'd3, 16'd3, 32'h5, "R8 absent beats privilege and limit");
    send(2'd0, 16'd8, 32'h0, "R5 index equals table size");
    send(2'd0, 16'hFFFF, 32'h0, "R5 max index");
    send(2'd0, 16'd9, 32'h0, "R5 R8 out of range ignores written slot");
    send(2'd3, 16'd4, 32'h0, "R9 user table write ignored");
    send(2'd2, 16'd5, 32'h0F, "R3 R7 equal privilege allowed");
    send(2'd3, 16'd5, 32'h0F, "R7 lower privilege refused");
    send(2'd3, 16'd5, 32'h10, "R8 privilege beats limit");
    send(2'd0, 16'd6, 32'h0, "R4 zero limit faults");
    send(2'd3, 16'd7, 32'h20, "R3 base plus offset wraps");
    drain();

    // R10: back-to-back burst under random back-pressure
    bp_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      send(rnd[1:0], {12'd0, rnd[7:4]}, {20'd0, rnd[19:8]}, "R10 burst");
    end
    drain();
    bp_en = 1'b0;
    repeat (2) @(posedge clk); #1;

    // R2: back to real mode
    wr_pe(2'd0, 1'b0);
    send(2'd3, 16'd8, 32'h7, "R2 real mode restored");
    drain();

    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule